// File: doc/BRIEF.md
# Configuration EEPROM Command Controller

This block lets a host access a small nonvolatile array of 16-bit words through two registers. The host writes a command word: a 2-bit operation code and a 6-bit word address. It also writes a data register that supplies the value for stores and receives the value from loads. The block models the array internally and holds every operation for a fixed, configurable number of cycles. This stands in for the latency of a real serial memory device. While an operation runs, bit 15 of the command register reads as 1.

Stores and erases take effect only after a separate enable command, and that enable is used up by the next store or erase. So the usual update sequence is: enable, erase the word, load the data register, enable again, store. A further sub-command walks the words from address 0 through a configurable last address. It folds the high and low byte of each word together with XOR and leaves the resulting byte in the data register. The host can then store that byte at the next address as an integrity checksum.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: After reset the busy bit is 0, the data register reads 0, the command readback reads 0, and every array word reads 0xFFFF.
- R2: A command's bits 7:6 give the operation: 1 = store, 2 = load, 3 = erase, 0 = miscellaneous. Its bits 5:0 give the word address, or the sub-code when the operation is 0. Sub-code 0x30 is write-enable and sub-code 0x20 is checksum. Any other sub-code is a timed no-op.
- R3: After an accepted load, store, erase or miscellaneous command, command-register bit 15 reads 1 for exactly ACC_DLY clock cycles, starting the cycle after the command is written.
- R4: When a load finishes, the data register holds the addressed word.
- R5: An erase issued after a write-enable sets the addressed word to 0xFFFF.
- R6: A store issued after a write-enable copies the data register into the addressed word.
- R7: A store or erase without a preceding write-enable finishes with busy timing as normal and leaves the array unchanged.
- R8: The write-enable is consumed by each store or erase, so the next modification needs a fresh enable.
- R9: Command writes and data-register writes that arrive while busy are ignored.
- R10: A data-register write accepted while idle loads the value and holds busy for ACC_DLY cycles.
- R11: The checksum sub-command leaves in data-register bits 7:0 the XOR of both bytes of every word from address 0 through CSUM_LAST, with bits 15:8 at 0. Busy stays set until this value is ready.
- R12: Command-register bits 14:0 read back the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 15 | Command word (bit 15 of the register is read-only) |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| cmd_rdata | output | 16 | Busy flag in bit 15, last command in bits 14:0 |
| data_rdata | output | 16 | Data register contents |

## Verification
Loads are tried at the lowest, a middle and the highest address, with distinct bit patterns, so that swapped address or data bits stand out. Stores and erases run both with and without a prior enable, and twice in a row after a single enable. This separates correct gating from a missing gate or an enable that persists. Commands and data writes are also sent in the middle of a busy period; a design that wrongly accepts them shows a changed data register or a changed word. The checksum runs over an array with several non-erased words, placed both inside and just past the covered range. This catches off-by-one range errors and byte-folding errors.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int EEP_AW = 6;
    localparam int EEP_DW = 16;
    localparam int EEP_BW = EEP_DW / 2;
    localparam int EEP_WORDS = 1 << EEP_AW;

    typedef enum logic [1:0] {
        OP_MISC  = 2'd0,
        OP_STORE = 2'd1,
        OP_LOAD  = 2'd2,
        OP_ERASE = 2'd3
    } eep_op_e;

    localparam logic [EEP_AW-1:0] SUB_ENABLE = 6'h30;
    localparam logic [EEP_AW-1:0] SUB_CSUM   = 6'h20;
    localparam logic [EEP_AW-1:0] SUB_NOP    = 6'h00;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUM  = 2'd2
    } eep_state_e;
endpackage

// File: rtl/eep_timer.sv
module eep_timer #(
    parameter int ACC_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(ACC_DLY + 1);
    localparam logic [CW-1:0] LOAD = CW'(ACC_DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CW'(1));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);
endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [EEP_AW-1:0] waddr,
    input  logic [EEP_DW-1:0] wdata,
    input  logic [EEP_AW-1:0] raddr,
    output logic [EEP_DW-1:0] rdata,
    input  logic [EEP_AW-1:0] saddr,
    output logic [EEP_DW-1:0] sdata
);
    logic [EEP_DW-1:0] mem_q [EEP_WORDS];

    generate
        for (genvar w = 0; w < EEP_WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[w] <= '1;
                else if (we && waddr == EEP_AW'(w))
                    mem_q[w] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem_q[raddr];
    assign sdata = mem_q[saddr];
endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
    import eep_pkg::*;
#(
    parameter int ACC_DLY   = 4,
    parameter int CSUM_LAST = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [14:0] cmd_wdata,
    input  logic        data_wr,
    input  logic [15:0] data_wdata,
    output logic [15:0] cmd_rdata,
    output logic [15:0] data_rdata
);
    localparam logic [EEP_AW-1:0] SUM_END = EEP_AW'(CSUM_LAST);

    typedef struct packed {
        eep_state_e        state;
        eep_op_e           op;
        logic [EEP_AW-1:0] addr;
        logic              wen;
        logic [EEP_DW-1:0] data;
        logic [14:0]       cmd_last;
        logic [EEP_AW-1:0] idx;
        logic [EEP_BW-1:0] acc;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic              tmr_start, tmr_done;
    logic              st_we;
    logic [EEP_DW-1:0] st_wdata, st_rdata, st_sdata;
    logic              busy;

    eep_timer #(.ACC_DLY(ACC_DLY)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    eep_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (r_q.addr),
        .wdata (st_wdata),
        .raddr (r_q.addr),
        .rdata (st_rdata),
        .saddr (r_q.idx),
        .sdata (st_sdata)
    );

    assign st_wdata = (r_q.op == OP_ERASE) ? '1 : r_q.data;
    assign busy     = (r_q.state != ST_IDLE);

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        st_we     = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    r_d.cmd_last = cmd_wdata;
                    r_d.op       = eep_op_e'(cmd_wdata[7:6]);
                    r_d.addr     = cmd_wdata[5:0];
                    if (eep_op_e'(cmd_wdata[7:6]) == OP_MISC && cmd_wdata[5:0] == SUB_CSUM) begin
                        r_d.state = ST_SUM;
                        r_d.idx   = '0;
                        r_d.acc   = '0;
                    end else begin
                        r_d.state = ST_RUN;
                        tmr_start = 1'b1;
                    end
                end else if (data_wr) begin
                    r_d.data  = data_wdata;
                    r_d.op    = OP_MISC;
                    r_d.addr  = SUB_NOP;
                    r_d.state = ST_RUN;
                    tmr_start = 1'b1;
                end
            end
            ST_RUN: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    unique case (r_q.op)
                        OP_LOAD: r_d.data = st_rdata;
                        OP_STORE, OP_ERASE: begin
                            st_we   = r_q.wen;
                            r_d.wen = 1'b0;
                        end
                        OP_MISC: begin
                            if (r_q.addr == SUB_ENABLE)
                                r_d.wen = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_SUM: begin
                r_d.acc = r_q.acc ^ st_sdata[EEP_DW-1:EEP_BW] ^ st_sdata[EEP_BW-1:0];
                if (r_q.idx == SUM_END) begin
                    r_d.data  = {{(EEP_DW-EEP_BW){1'b0}}, r_d.acc};
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.op       <= OP_MISC;
            r_q.addr     <= '0;
            r_q.wen      <= 1'b0;
            r_q.data     <= '0;
            r_q.cmd_last <= '0;
            r_q.idx      <= '0;
            r_q.acc      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_rdata  = {busy, r_q.cmd_last};
    assign data_rdata = r_q.data;

    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && (cmd_wr || data_wr) |=> cmd_rdata[15]);
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN) && !tmr_done |=> $stable(data_rdata));
    p_enable_used_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN) && tmr_done && (r_q.op == OP_STORE || r_q.op == OP_ERASE) |=> !r_q.wen);
    p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_rdata[14:0]));
    p_sum_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SUM) |-> r_q.idx <= SUM_END);
endmodule

// File: tb/sim_eep_cmd_ctrl.sv
module sim_eep_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [14:0] cmd_wdata = '0;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [15:0] cmd_rdata, data_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [64];

    localparam int DLY  = 4;
    localparam int LAST = 31;

    always #4 clk = ~clk;

    eep_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .cmd_rdata(cmd_rdata), .data_rdata(data_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] mk(input logic [1:0] op, input logic [5:0] a);
        return {7'b0, op, a};
    endfunction

    task automatic issue(input logic [14:0] c);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic put_data(input logic [15:0] d);
        @(negedge clk); data_wr = 1'b1; data_wdata = d;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && cmd_rdata[15]; i++) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [14:0] c);
        issue(c); wait_idle();
    endtask

    task automatic load(input logic [5:0] a, output logic [15:0] v);
        do_cmd(mk(2'd2, a)); v = data_rdata;
    endtask

    task automatic set_data(input logic [15:0] d);
        put_data(d); wait_idle();
    endtask

    task automatic program_word(input logic [5:0] a, input logic [15:0] d);
        do_cmd(15'h30); do_cmd(mk(2'd3, a)); set_data(d);
        do_cmd(15'h30); do_cmd(mk(2'd1, a));
        model[a] = d;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check(cmd_rdata == 16'h0, "R1 cmd reg", cmd_rdata, 16'h0);
        check(data_rdata == 16'h0, "R1 data reg", data_rdata, 16'h0);
        load(6'h00, v); check(v == 16'hFFFF, "R1 word0", v, 16'hFFFF);
        load(6'h3F, v); check(v == 16'hFFFF, "R1 word3F", v, 16'hFFFF);
    endtask

    task automatic t_timing();
        int n = 0;
        issue(15'h30);
        while (cmd_rdata[15] && n < 100) begin n++; @(negedge clk); end
        check(n == DLY, "R3 busy length", 16'(n), 16'(DLY));
        check(cmd_rdata[14:0] == 15'h30, "R12 readback", {1'b0, cmd_rdata[14:0]}, 16'h30);
        n = 0;
        put_data(16'h5A5A);
        while (cmd_rdata[15] && n < 100) begin n++; @(negedge clk); end
        check(n == DLY, "R10 data busy length", 16'(n), 16'(DLY));
        check(data_rdata == 16'h5A5A, "R10 data value", data_rdata, 16'h5A5A);
        n = 0;
        issue(mk(2'd0, 6'h05));
        while (cmd_rdata[15] && n < 100) begin n++; @(negedge clk); end
        check(n == DLY, "R2 nop sub-code busy length", 16'(n), 16'(DLY));
    endtask

    task automatic t_store_load();
        logic [15:0] v;
        program_word(6'h05, 16'h1234);
        program_word(6'h3F, 16'hC3A5);
        program_word(6'h00, 16'h8001);
        load(6'h05, v); check(v == 16'h1234, "R6 R4 addr05", v, 16'h1234);
        load(6'h3F, v); check(v == 16'hC3A5, "R6 R4 addr3F", v, 16'hC3A5);
        load(6'h00, v); check(v == 16'h8001, "R6 R4 addr00", v, 16'h8001);
        check(cmd_rdata[14:0] == 15'h080, "R12 load readback", {1'b0, cmd_rdata[14:0]}, 16'h080);
    endtask

    task automatic t_erase();
        logic [15:0] v;
        do_cmd(15'h30); do_cmd(mk(2'd3, 6'h05)); model[5] = 16'hFFFF;
        load(6'h05, v); check(v == 16'hFFFF, "R5 erase", v, 16'hFFFF);
    endtask

    task automatic t_no_enable();
        logic [15:0] v;
        set_data(16'hAAAA); do_cmd(mk(2'd1, 6'h07));
        load(6'h07, v); check(v == 16'hFFFF, "R7 store without enable", v, 16'hFFFF);
        do_cmd(mk(2'd3, 6'h3F));
        load(6'h3F, v); check(v == 16'hC3A5, "R7 erase without enable", v, 16'hC3A5);
    endtask

    task automatic t_enable_used();
        logic [15:0] v;
        set_data(16'h0F0F); do_cmd(15'h30);
        do_cmd(mk(2'd1, 6'h09)); model[9] = 16'h0F0F;
        do_cmd(mk(2'd1, 6'h0A));
        load(6'h09, v); check(v == 16'h0F0F, "R8 first store", v, 16'h0F0F);
        load(6'h0A, v); check(v == 16'hFFFF, "R8 second store blocked", v, 16'hFFFF);
        do_cmd(15'h30); do_cmd(mk(2'd3, 6'h09)); do_cmd(mk(2'd3, 6'h00));
        load(6'h00, v); check(v == 16'h8001, "R8 erase consumes enable", v, 16'h8001);
        model[9] = 16'hFFFF;
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        do_cmd(15'h30);
        issue(mk(2'd2, 6'h3F));
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = mk(2'd3, 6'h00); data_wr = 1'b1; data_wdata = 16'h7777;
        @(negedge clk); cmd_wr = 1'b0; data_wr = 1'b0;
        wait_idle();
        check(data_rdata == 16'hC3A5, "R9 data write ignored", data_rdata, 16'hC3A5);
        check(cmd_rdata[14:0] == 15'h0BF, "R9 command ignored", {1'b0, cmd_rdata[14:0]}, 16'h0BF);
        load(6'h00, v); check(v == 16'h8001, "R9 erase ignored", v, 16'h8001);
        do_cmd(mk(2'd3, 6'h3F)); model[63] = 16'hFFFF;
    endtask

    task automatic t_checksum();
        logic [7:0] exp = 8'h00;
        program_word(6'h1F, 16'h1357);
        program_word(6'h20, 16'h00FE);
        program_word(6'h11, 16'hBEEF);
        for (int a = 0; a <= LAST; a++) exp ^= model[a][15:8] ^ model[a][7:0];
        do_cmd(15'h20);
        check(data_rdata == {8'h00, exp}, "R11 checksum", data_rdata, {8'h00, exp});
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_store_load();
        t_erase();
        t_no_enable();
        t_enable_used();
        t_busy_ignore();
        t_checksum();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule